// File: doc/BRIEF.md
# Switch Port Mirroring Selector

This block sits between the address lookup of a three-port switch and its frame forwarding stage. For every frame the lookup presents the port the frame came in on and the set of ports it should leave on. The block returns that set, possibly widened by one bit, so that a copy of the frame also goes to a monitoring port. The frame still reaches every port the lookup chose.

Each port has a small configuration register with three bits. One bit makes the port watched for traffic it receives. One bit makes it watched for traffic it sends. One bit designates it as the port that collects the copies. A further global register chooses between two rules. Under the union rule, a frame is copied if either watch condition holds. Under the intersection rule, a frame is copied only when both hold.

Requests arrive on a valid/ready handshake. The widened mask comes back from a single output register, also on a valid/ready handshake. The block holds no frame data.

Top module: `mirror_mask_sel`

## Requirements
- R1: After reset, `out_valid` is low, `req_ready` is high, and every configuration bit is clear, so no frame is mirrored.
- R2: A write with `cfg_addr` equal to a port index p (0..NPORTS-1) loads that port's register. In that register, `cfg_wdata[0]` marks p as receive-watched, `cfg_wdata[1]` marks p as transmit-watched and `cfg_wdata[2]` designates p as the monitor. A write with `cfg_addr` equal to NPORTS loads `cfg_wdata[0]` as the intersection-mode bit.
- R3: While no port is designated as monitor, `out_mask` equals the request's `req_mask`.
- R4: In union mode (intersection bit 0), a frame is copied when its ingress port is receive-watched or any port set in `req_mask` is transmit-watched.
- R5: In intersection mode (intersection bit 1), a frame is copied only when its ingress port is receive-watched and at least one port set in `req_mask` is transmit-watched.
- R6: For a copied frame, `out_mask` is `req_mask` with the monitor port's bit (bit i stands for port i) also set. For any frame, `out_mask` contains every bit of `req_mask` and at most one extra bit.
- R7: A frame whose `req_src` is the monitor port is never copied. A request with an all-zero `req_mask` yields an all-zero `out_mask`.
- R8: When several ports carry the monitor designation, the one with the lowest index is the monitor.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is in `out_mask` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_mask` holds and `req_ready` is low.
- R10: A request accepted on the same edge as a configuration write is decided with the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NPORTS+1) | Register select: port index, or NPORTS for the global mode |
| cfg_wdata | input | 3 | Register write data |
| req_valid | input | 1 | Lookup result is present |
| req_ready | output | 1 | Block can take a lookup result |
| req_src | input | $clog2(NPORTS) | Ingress port of the frame |
| req_mask | input | NPORTS | Destination ports from the lookup, bit i = port i |
| out_valid | output | 1 | Final mask is present |
| out_ready | input | 1 | Consumer takes the final mask |
| out_mask | output | NPORTS | Final destination mask including any monitor copy |

## Verification
The hardest case to reach is a request that is accepted on the same clock edge as a write which would change the answer. Reaching it needs the configuration strobe and the request handshake raised in the same half cycle. The stimulus does this after a receive-watched port has been set up, then clears that port's register together with the request. The result shows the old answer, and a follow-up request shows the new one. A second hard case is back-pressure with a new request already waiting. The bench holds `out_ready` low for several cycles with a second request pending, then checks that the first mask held and that the second request goes in only when the consumer releases.

// File: rtl/mirsel_pkg.sv
package mirsel_pkg;
   // bit positions inside one port's control register
   localparam int unsigned CFG_RX_BIT  = 0;
   localparam int unsigned CFG_TX_BIT  = 1;
   localparam int unsigned CFG_MON_BIT = 2;
   localparam int unsigned CFG_W       = 3;

   typedef enum logic {
      MODE_UNION     = 1'b0,
      MODE_INTERSECT = 1'b1
   } mir_mode_e;
endpackage

// File: rtl/mirsel_cfg.sv
module mirsel_cfg
   import mirsel_pkg::*;
#(
   parameter int unsigned NPORTS = 3,
   parameter int unsigned AW     = $clog2(NPORTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [CFG_W-1:0]  wdata,
   output logic [NPORTS-1:0] rx_vec,
   output logic [NPORTS-1:0] tx_vec,
   output logic [NPORTS-1:0] mon_vec,
   output mir_mode_e         mode
);
   localparam logic [AW-1:0] GLOBAL_ADDR = AW'(NPORTS);

   generate
      if ((1 << AW) <= NPORTS) begin : g_bad_aw
         $error("mirsel_cfg: AW too narrow for NPORTS+1 registers");
      end
   endgenerate

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [CFG_W-1:0] reg_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            reg_q <= '0;
         else if (we && addr == AW'(p))
            reg_q <= wdata;
      end
      assign rx_vec[p]  = reg_q[CFG_RX_BIT];
      assign tx_vec[p]  = reg_q[CFG_TX_BIT];
      assign mon_vec[p] = reg_q[CFG_MON_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= MODE_UNION;
      else if (we && addr == GLOBAL_ADDR)
         mode <= mir_mode_e'(wdata[0]);
   end
endmodule

// File: rtl/mirsel_monpick.sv
module mirsel_monpick #(
   parameter int unsigned NPORTS = 3
) (
   input  logic [NPORTS-1:0] mon_vec,
   output logic [NPORTS-1:0] mon_oh,
   output logic              mon_any
);
   // lowest set bit wins
   always_comb begin
      mon_oh = mon_vec & (~mon_vec + NPORTS'(1));
      mon_any = |mon_vec;
   end

   // R8
   always_comb begin
      mon_onehot_chk: assert ($onehot0(mon_oh))
         else $error("monitor selection not one-hot: %b", mon_oh);
   end
endmodule

// File: rtl/mirsel_decide.sv
module mirsel_decide
   import mirsel_pkg::*;
#(
   parameter int unsigned NPORTS       = 3,
   parameter bit          INTERSECT_EN = 1'b1,
   parameter int unsigned PW           = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic [PW-1:0]     src,
   input  logic [NPORTS-1:0] mask,
   input  logic [NPORTS-1:0] rx_vec,
   input  logic [NPORTS-1:0] tx_vec,
   input  logic [NPORTS-1:0] mon_oh,
   input  logic              mon_any,
   input  mir_mode_e         mode,
   output logic [NPORTS-1:0] mask_out
);
   localparam int unsigned SPAN = 1 << PW;

   logic [SPAN-1:0] rx_pad;
   logic [SPAN-1:0] mon_pad;
   logic            rx_hit;
   logic            tx_hit;
   logic            self_mon;
   logic            want_copy;
   logic            copy;

   always_comb begin
      rx_pad   = SPAN'(rx_vec);
      mon_pad  = SPAN'(mon_oh);
      rx_hit   = rx_pad[src];
      self_mon = mon_pad[src];
      tx_hit   = |(mask & tx_vec);
   end

   generate
      if (INTERSECT_EN) begin : g_both_modes
         always_comb
            want_copy = (mode == MODE_INTERSECT) ? (rx_hit & tx_hit)
                                                 : (rx_hit | tx_hit);
      end else begin : g_union_only
         always_comb want_copy = rx_hit | tx_hit;
      end
   endgenerate

   always_comb begin
      copy     = mon_any & (|mask) & ~self_mon & want_copy;
      mask_out = mask | (copy ? mon_oh : '0);
   end
endmodule

// File: rtl/mirror_mask_sel.sv
module mirror_mask_sel
   import mirsel_pkg::*;
#(
   parameter int unsigned NPORTS       = 3,
   parameter bit          INTERSECT_EN = 1'b1,
   localparam int unsigned PW          = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int unsigned CFG_AW      = $clog2(NPORTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [2:0]        cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PW-1:0]     req_src,
   input  logic [NPORTS-1:0] req_mask,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [NPORTS-1:0] out_mask
);
   generate
      if (NPORTS < 2 || NPORTS > 16) begin : g_bad_ports
         $error("mirror_mask_sel: NPORTS must lie in 2..16");
      end
   endgenerate

   logic [NPORTS-1:0] rx_vec, tx_vec, mon_vec, mon_oh, dec_mask;
   logic              mon_any;
   mir_mode_e         mode;
   logic              accept;

   mirsel_cfg #(.NPORTS(NPORTS), .AW(CFG_AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .rx_vec(rx_vec), .tx_vec(tx_vec), .mon_vec(mon_vec), .mode(mode)
   );

   mirsel_monpick #(.NPORTS(NPORTS)) u_pick (
      .mon_vec(mon_vec), .mon_oh(mon_oh), .mon_any(mon_any)
   );

   mirsel_decide #(.NPORTS(NPORTS), .INTERSECT_EN(INTERSECT_EN), .PW(PW)) u_dec (
      .src(req_src), .mask(req_mask), .rx_vec(rx_vec), .tx_vec(tx_vec),
      .mon_oh(mon_oh), .mon_any(mon_any), .mode(mode), .mask_out(dec_mask)
   );

   assign req_ready = ~out_valid | out_ready;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_mask  <= dec_mask;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R9
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));

   // R9
   accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   // R6
   keeps_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ((out_mask & $past(req_mask)) == $past(req_mask)));

   // R6
   one_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ($countones(out_mask & ~$past(req_mask)) <= 1));

   // R7
   empty_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mask == '0) |=> (out_mask == '0));

   // R3
   no_monitor_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !mon_any) |=> (out_mask == $past(req_mask)));

   // R7
   self_monitor_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (int'(req_src) < NPORTS) && ((mon_oh >> req_src) & NPORTS'(1)) != '0)
      |=> (out_mask == $past(req_mask)));
endmodule

// File: tb/sim_mirror_mask_sel.sv
`timescale 1ns/1ps
module sim_mirror_mask_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [2:0] cfg_wdata = '0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_src = '0;
   logic [2:0] req_mask = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [2:0] out_mask;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   mirror_mask_sel u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_mask(req_mask), .out_valid(out_valid),
      .out_ready(out_ready), .out_mask(out_mask)
   );

   task automatic chk(input bit ok, input string tag, input logic [2:0] act,
                      input logic [2:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [2:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [1:0] s, input logic [2:0] m,
                       input logic [2:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_src = s; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      chk(out_valid === 1'b1 && out_mask === exp, tag, out_mask, exp);
   endtask

   task automatic t_reset;
      chk(out_valid === 1'b0 && req_ready === 1'b1, "R1 reset handshake",
          {1'b0, req_ready, out_valid}, 3'b010);
      send(2'd0, 3'b010, 3'b010, "R1 no mirroring after reset");
   endtask

   task automatic t_union;
      wr(2'd0, 3'b001);
      send(2'd0, 3'b010, 3'b010, "R3 rx-watched but no monitor");
      wr(2'd2, 3'b100);
      send(2'd0, 3'b010, 3'b110, "R4 R6 rx-watched copy to port2");
      send(2'd1, 3'b001, 3'b001, "R4 no watch condition");
      wr(2'd0, 3'b011);
      send(2'd1, 3'b001, 3'b101, "R4 R2 tx-watched destination");
   endtask

   task automatic t_exclusions;
      send(2'd2, 3'b001, 3'b001, "R7 frame from monitor port");
      send(2'd0, 3'b000, 3'b000, "R7 empty mask");
   endtask

   task automatic t_intersect;
      wr(2'd3, 3'b001);
      send(2'd0, 3'b010, 3'b010, "R5 rx only not copied");
      wr(2'd1, 3'b010);
      send(2'd0, 3'b010, 3'b110, "R5 rx and tx copied");
      send(2'd1, 3'b001, 3'b001, "R5 tx only not copied");
      wr(2'd3, 3'b000);
   endtask

   task automatic t_priority;
      wr(2'd1, 3'b110);
      send(2'd0, 3'b100, 3'b110, "R8 lowest monitor port1");
      send(2'd2, 3'b001, 3'b011, "R8 tx copy to port1");
   endtask

   task automatic t_stall;
      @(negedge clk);
      out_ready = 1'b0;
      req_valid = 1'b1; req_src = 2'd0; req_mask = 3'b100;
      @(negedge clk);
      req_src = 2'd2; req_mask = 3'b100;
      chk(out_valid === 1'b1 && out_mask === 3'b110, "R9 first result", out_mask, 3'b110);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(out_mask === 3'b110 && out_valid === 1'b1 && req_ready === 1'b0,
             "R9 held under stall", out_mask, 3'b110);
      end
      out_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(out_valid === 1'b1 && out_mask === 3'b100, "R9 second after release",
          out_mask, 3'b100);
   endtask

   task automatic t_same_edge;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 3'b000;
      req_valid = 1'b1; req_src = 2'd0; req_mask = 3'b100;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk(out_valid === 1'b1 && out_mask === 3'b110, "R10 old config used",
          out_mask, 3'b110);
      send(2'd0, 3'b100, 3'b100, "R10 R2 new config after write");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_union;
      t_exclusions;
      t_intersect;
      t_priority;
      t_stall;
      t_same_edge;
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule